// File: doc/BRIEF.md
# Retriggerable Dead-Time Pair Generator

This block turns one digital source waveform into two complementary drive signals, `drv_lead` and `drv_lag`. They are never active at the same time, and a programmable dead time separates them. When the source rises, `drv_lag` is released at once and a single shared down-counter is loaded from `dead_cycles`. `drv_lead` becomes active only when the counter expires. A falling source edge does the mirror action: `drv_lead` is released at once and `drv_lag` is asserted after the dead time. Every source edge reloads the same counter, even while it is still running. As a result, a source pulse shorter than the dead time never reaches the delayed output, and the other output returns only one dead time after the last edge.

The block sits between a selected source (a compare output or a pulse generator output, picked elsewhere) and a pair of power-stage drive pins. The `invert` input inverts both outputs for drivers that are active low. A one-cycle `enter` strobe, issued when the owning waveform generator switches into this mode, sets both outputs directly from the current source level. While `enable` is low, both outputs sit at their inactive level and the counter is idle.

Top module: `deadtime_pair`

## Requirements
- R1: A rising source edge sampled at clock edge k makes `drv_lag` inactive after edge k. It makes `drv_lead` active after edge k+D+1, where D is `dead_cycles`, unless another source edge is sampled first.
- R2: A falling source edge sampled at clock edge k makes `drv_lead` inactive after edge k. It makes `drv_lag` active after edge k+D+1, unless another source edge is sampled first.
- R3: Every sampled source edge reloads the dead-time counter with `dead_cycles`, including while a count is in progress. After a run of edges, the delayed output follows only the last edge, D+1 cycles later.
- R4: If the source stays high for H sampled cycles with H ≤ D+1, `drv_lead` shows no active pulse at all. If H > D+1, it is active for H−D−1 cycles.
- R5: `drv_lead` and `drv_lag` are never both at their active level in the same cycle.
- R6: With `dead_cycles` = 0, the delayed output changes one cycle after the output released at once.
- R7: With `invert` = 1, the active level of both outputs is 0 and the inactive level is 1. With `invert` = 0, active is 1.
- R8: An `enter` pulse while enabled sets `drv_lead` to the active level if the source is high (inactive if low), sets `drv_lag` to the opposite, and stops any running count. Enter takes priority over a source edge in the same cycle.
- R9: While `enable` = 0, both outputs are at their inactive level, and source edges and `enter` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low holds both outputs inactive |
| src | input | 1 | Source waveform, sampled every clock |
| enter | input | 1 | One-cycle mode-entry strobe that presets the outputs from the source |
| dead_cycles | input | CNT_W (16) | Dead time in clock cycles; delay is dead_cycles+1 |
| invert | input | 1 | 1 = outputs active low |
| drv_lead | output | 1 | Output that follows the source after the dead time on rising edges |
| drv_lag | output | 1 | Complementary output, active after the dead time on falling edges |

## Verification
Single source pulses are applied with high times well above, exactly at, one above and below the D+1 boundary. The trace shows whether `drv_lead` pulses, how wide the pulse is, and when `drv_lag` returns, so a wrong reload, a wrong expiry priority or an off-by-one delay each show a different width or return cycle. Zero and short dead times, in both polarities, separate the immediate path from the delayed path. A rise-fall-rise burst inside one dead time shows that only the last edge times the output. Preset from both source levels and both polarities, and enable-low runs with toggling source and strobes, confirm the entry and idle behaviour.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;
   typedef enum logic {
      DIR_FALL = 1'b0,
      DIR_RISE = 1'b1
   } edge_dir_e;

   typedef struct packed {
      logic      valid;
      edge_dir_e dir;
   } edge_evt_t;
endpackage

// File: rtl/deadtime_edge_det.sv
module deadtime_edge_det
   import deadtime_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  logic      src_i,
   output logic      lvl_o,
   output edge_evt_t evt_o
);
   logic prev_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("SYNC_STAGES must not be negative");
      end else if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_o = src_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= src_i;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], src_i} ;
         end
         assign lvl_o = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // previous level always tracks, so enabling never creates a false edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   always_comb begin
      evt_o.valid = enable && (lvl_o != prev_q);
      evt_o.dir   = lvl_o ? DIR_RISE : DIR_FALL;
   end
endmodule

// File: rtl/deadtime_counter.sv
module deadtime_counter
   import deadtime_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             clear,
   input  edge_evt_t        evt_i,
   input  logic [CNT_W-1:0] load_i,
   output edge_evt_t        fire_o
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   edge_dir_e        dir_q;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W must be in 1..32");
      end
   endgenerate

   // expiry loses to a new edge and to clear in the same cycle
   always_comb begin
      fire_o.valid = enable && !clear && !evt_i.valid && busy_q && (cnt_q == ZERO);
      fire_o.dir   = dir_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ZERO;
         busy_q <= 1'b0;
         dir_q  <= DIR_FALL;
      end else if (!enable || clear) begin
         cnt_q  <= ZERO;
         busy_q <= 1'b0;
      end else if (evt_i.valid) begin
         cnt_q  <= load_i;
         busy_q <= 1'b1;
         dir_q  <= evt_i.dir;
      end else if (busy_q) begin
         if (cnt_q == ZERO) busy_q <= 1'b0;
         else               cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R3: each edge reloads the counter
   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !clear && evt_i.valid) |=> (busy_q && cnt_q == $past(load_i)));

   // R3: a running count steps down by one when undisturbed
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !clear && !evt_i.valid && busy_q && cnt_q != ZERO)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R9: disabled counter goes idle
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy_q);
endmodule

// File: rtl/deadtime_pair_ctrl.sv
module deadtime_pair_ctrl
   import deadtime_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  logic      enter,
   input  logic      lvl_i,
   input  edge_evt_t evt_i,
   input  edge_evt_t fire_i,
   output logic      lead_o,
   output logic      lag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_o <= 1'b0;
         lag_o  <= 1'b0;
      end else if (!enable) begin
         lead_o <= 1'b0;
         lag_o  <= 1'b0;
      end else if (enter) begin
         lead_o <= lvl_i;
         lag_o  <= !lvl_i;
      end else if (evt_i.valid) begin
         if (evt_i.dir == DIR_RISE) lag_o  <= 1'b0;
         else                       lead_o <= 1'b0;
      end else if (fire_i.valid) begin
         if (fire_i.dir == DIR_RISE) lead_o <= 1'b1;
         else                        lag_o  <= 1'b1;
      end
   end

   // R5: never both active
   p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_o && lag_o));

   // R1: rising edge releases lag output at once
   p_rise_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !enter && evt_i.valid && evt_i.dir == DIR_RISE) |=> !lag_o);

   // R2: falling edge releases lead output at once
   p_fall_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !enter && evt_i.valid && evt_i.dir == DIR_FALL) |=> !lead_o);

   // R8: entry presets from the source level
   p_enter_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && enter) |=> (lead_o == $past(lvl_i) && lag_o == !$past(lvl_i)));

   // R9: disabled holds both inactive
   p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!lead_o && !lag_o));
endmodule

// File: rtl/deadtime_pair.sv
module deadtime_pair
   import deadtime_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             src,
   input  logic             enter,
   input  logic [CNT_W-1:0] dead_cycles,
   input  logic             invert,
   output logic             drv_lead,
   output logic             drv_lag
);
   logic      lvl;
   edge_evt_t evt;
   edge_evt_t fire;
   logic      lead_n;
   logic      lag_n;

   deadtime_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .src_i  (src),
      .lvl_o  (lvl),
      .evt_o  (evt)
   );

   deadtime_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .clear  (enter),
      .evt_i  (evt),
      .load_i (dead_cycles),
      .fire_o (fire)
   );

   deadtime_pair_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .enter  (enter),
      .lvl_i  (lvl),
      .evt_i  (evt),
      .fire_i (fire),
      .lead_o (lead_n),
      .lag_o  (lag_n)
   );

   // R7: polarity applied at the pins
   assign drv_lead = lead_n ^ invert;
   assign drv_lag  = lag_n ^ invert;
endmodule

// File: tb/deadtime_pair_bench.sv
`timescale 1ns/1ps
module deadtime_pair_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        src = 1'b0;
   logic        enter = 1'b0;
   logic [15:0] dead_cycles = '0;
   logic        invert = 1'b0;
   logic        drv_lead, drv_lag;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   deadtime_pair u_deadtime_pair (
      .clk(clk), .rst_n(rst_n), .enable(enable), .src(src), .enter(enter),
      .dead_cycles(dead_cycles), .invert(invert),
      .drv_lead(drv_lead), .drv_lag(drv_lag)
   );

   // {dead[15:0], invert[7:0], high_cycles[7:0]}
   localparam logic [31:0] VEC [8] = '{
      {16'd3, 8'd0, 8'd10},
      {16'd0, 8'd0, 8'd1 },
      {16'd0, 8'd1, 8'd4 },
      {16'd5, 8'd1, 8'd3 },
      {16'd5, 8'd0, 8'd6 },
      {16'd5, 8'd0, 8'd7 },
      {16'd2, 8'd1, 8'd8 },
      {16'd1, 8'd0, 8'd2 }
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic preset(input logic lvl);
      @(negedge clk);
      src = lvl;
      enter = 1'b1;
      @(negedge clk);
      enter = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      // reset state, disabled
      repeat (3) @(negedge clk);
      chk("R9 reset lead", drv_lead, 0);
      chk("R9 reset lag", drv_lag, 0);
      rst_n = 1'b1;

      // R9: disabled with inverted polarity, source toggles and strobes ignored
      invert = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         src = ~src;
         enter = (i == 2);
      end
      @(negedge clk);
      enter = 1'b0;
      chk("R9 disabled lead inactive", drv_lead, 1);
      chk("R9 disabled lag inactive", drv_lag, 1);

      enable = 1'b1;

      // vector table walk: R1 R2 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         int d, h, ph, ret, ovl, lag0;
         logic inv;
         d   = int'(VEC[v][31:16]);
         inv = VEC[v][8];
         h   = int'(VEC[v][7:0]);
         invert = inv;
         dead_cycles = 16'(d);
         preset(1'b0);
         repeat (2) @(negedge clk);
         chk($sformatf("R8/R7 v%0d preset lag active", v), drv_lag ^ inv, 1);
         src = 1'b1;
         ph = 0; ret = -1; ovl = 0; lag0 = -1;
         for (int c = 0; c < h + d + 5; c++) begin
            @(negedge clk);
            if (c == 0) lag0 = drv_lag ^ inv;
            if ((drv_lead ^ inv) == 1'b1) ph++;
            if (((drv_lead ^ inv) & (drv_lag ^ inv)) == 1'b1) ovl++;
            if (c >= h && ret < 0 && (drv_lag ^ inv) == 1'b1) ret = c;
            if (c == h - 1) src = 1'b0;
         end
         chk($sformatf("R1 v%0d lag released at once", v), lag0, 0);
         chk($sformatf("R4 v%0d lead pulse width", v), ph, (h > d + 1) ? h - d - 1 : 0);
         chk($sformatf("R2/R6 v%0d lag return cycle", v), ret, h + d + 1);
         chk($sformatf("R5 v%0d overlap cycles", v), ovl, 0);
      end

      // R3: rise, fall, rise within one dead time; lead follows last edge
      begin
         int first_lead, lag_seen;
         invert = 1'b0;
         dead_cycles = 16'd4;
         preset(1'b0);
         @(negedge clk);
         src = 1'b1;           // seen at index 0
         first_lead = -1; lag_seen = 0;
         for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (drv_lead && first_lead < 0) first_lead = c;
            if (drv_lag) lag_seen++;
            if (c == 1) src = 1'b0;   // seen at index 2
            if (c == 3) src = 1'b1;   // seen at index 4
         end
         chk("R3 lead after last edge", first_lead, 9);
         chk("R3 lag never returns", lag_seen, 0);
      end

      // R8: preset from high source, both polarities
      invert = 1'b0;
      preset(1'b1);
      chk("R8 normal preset lead", drv_lead, 1);
      chk("R8 normal preset lag", drv_lag, 0);
      invert = 1'b1;
      preset(1'b1);
      chk("R8 reversed preset lead", drv_lead, 0);
      chk("R8 reversed preset lag", drv_lag, 1);

      // R8: enter wins over a simultaneous edge and stops a running count
      invert = 1'b0;
      dead_cycles = 16'd3;
      preset(1'b1);
      @(negedge clk);
      src = 1'b0;
      enter = 1'b1;
      @(negedge clk);
      enter = 1'b0;
      chk("R8 enter over edge lead", drv_lead, 0);
      chk("R8 enter over edge lag", drv_lag, 1);

      // R9: disabling mid-count drops outputs and the count never completes
      preset(1'b0);
      @(negedge clk);
      src = 1'b1;
      @(negedge clk);
      enable = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 disabled mid-count lead", drv_lead, 0);
      chk("R9 disabled mid-count lag", drv_lag, 0);

      finish_run();
   end
endmodule